// File: doc/BRIEF.md
# GPIO pin-mux control registers

This block holds the per-pin configuration for 32 general-purpose I/O pins. A mode register picks, for each pin, whether the pad serves its native function or acts as a GPIO. A direction register sets input or output for each pin that is in GPIO mode. Both registers sit behind a single-cycle register bus with zero-wait-state reads.

The pins are split across two reset domains. Pins 0-7 and 16-23 are in the core domain. Pins 8-15 and 24-31 are in the always-on domain. A full reset (`rst_ni`, asynchronous) restores every bit. A platform reset restores only the core-domain bits. A software reset restores every pin except pin 24.

Some mode bits are wired to GPIO. Pin 29 can be in GPIO mode only while a strap input is high. A lock input freezes both registers against bus writes.

From the two registers the block drives two outputs. The first is the native-side input, which sees a fixed inactive level while a pin is a GPIO. The second is the pad output enable.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After a full reset, with the strap high, a read at byte offset 0x0 returns 0xB96BA1FF. Bit n = 1 means pin n is a GPIO, and 0 means native.
- R2: After a full reset, the stored direction register is 0xF6FF6EFF. Bit n = 1 means input, and 0 means output. A read at offset 0x4 returns the stored direction ANDed with the effective mode.
- R3: Mode bits 8, 15, 24, 27 and 28 always read 1, whatever value is written.
- R4: Mode bit 29 reads 1 only when its stored bit is 1 and `strap_i` is 1. It acts as native otherwise.
- R5: A write at offset 0x4 updates only the direction bits of pins in GPIO mode. Direction bits of native pins read as 0.
- R6: While `lock_i` is 1, bus writes change neither register.
- R7: A platform reset pulse restores bits 0-7 and 16-23 of both registers to their reset values. The other bits keep their values.
- R8: A software reset pulse restores every bit of both registers except bit 24, which keeps its value.
- R9: `native_in_o[n]` equals `INACTIVE_LVL[n]` (default 0x0000FFFF) when pin n is a GPIO, and equals `pad_in_i[n]` otherwise.
- R10: `pad_oe_o[n]` is 1 only when pin n is a GPIO and its stored direction bit is 0.
- R11: Reads at any offset other than 0x0 and 0x4 return 0. Writes there change nothing.
- R12: Asserting `rst_ni` at any time restores both registers at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Full reset, active low, asynchronous |
| plt_rst_i | input | 1 | Platform reset pulse (core domain), synchronous |
| sw_rst_i | input | 1 | Software reset pulse, synchronous |
| lock_i | input | 1 | Blocks register writes |
| strap_i | input | 1 | Permits GPIO mode on pin 29 |
| addr_i | input | 4 | Byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pad_in_i | input | 32 | Pad input levels |
| native_in_o | output | 32 | Input seen by native logic |
| pad_oe_o | output | 32 | Pad output enable |

## Verification
The hardest case to reach is the overlap of the reset domains with prior writes. Bit 24 must survive a software reset, and resume-domain bits must survive a platform reset. These cases are only visible if the bits hold values other than their reset values first. The stimulus therefore fills both registers with non-default patterns, including direction bit 24, before each reset pulse. It then reads both offsets back.

The strap and the lock are toggled around writes to pin 29 and to direction bits of native pins. This shows the gating at the read port and at the pad enable.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int unsigned NPIN      = 32;
  localparam int unsigned ADDR_W    = 4;
  localparam logic [31:0] MODE_RST  = 32'hB96B_A1FF;
  localparam logic [31:0] DIR_RST   = 32'hF6FF_6EFF;
  localparam logic [31:0] HARD_MASK = 32'h1900_8100;
  localparam logic [31:0] CORE_MASK = 32'h00FF_00FF;
  localparam logic [31:0] INACT_DEF = 32'h0000_FFFF;
  localparam int unsigned KEEP_PIN  = 24;
  localparam int unsigned STRAP_PIN = 29;
  localparam logic [ADDR_W-1:0] MODE_OFS = 4'h0;
  localparam logic [ADDR_W-1:0] DIR_OFS  = 4'h4;
endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank #(
  parameter int unsigned N         = 32,
  parameter logic [N-1:0] RST_VAL  = '0,
  parameter logic [N-1:0] HARD     = '0,
  parameter logic [N-1:0] CORE     = '0,
  parameter int unsigned  KEEP     = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         plt_rst_i,
  input  logic         sw_rst_i,
  input  logic [N-1:0] we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (HARD[i]) begin : g_hard
      assign q_o[i] = 1'b1;
    end else begin : g_ff
      logic hit;
      assign hit = (sw_rst_i && (i != KEEP)) || (plt_rst_i && CORE[i]);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q_o[i] <= RST_VAL[i];
        else if (hit)    q_o[i] <= RST_VAL[i];
        else if (we_i[i]) q_o[i] <= d_i[i];
      end
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned  N        = 32,
  parameter logic [N-1:0] INACTIVE = '0
) (
  input  logic [N-1:0] gpio_mode_i,
  input  logic [N-1:0] dir_in_i,
  input  logic [N-1:0] pad_in_i,
  output logic [N-1:0] native_in_o,
  output logic [N-1:0] pad_oe_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign native_in_o[i] = gpio_mode_i[i] ? INACTIVE[i] : pad_in_i[i];
    assign pad_oe_o[i]    = gpio_mode_i[i] & ~dir_in_i[i];
  end
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter logic [NPIN-1:0] INACTIVE_LVL = INACT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              plt_rst_i,
  input  logic              sw_rst_i,
  input  logic              lock_i,
  input  logic              strap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   pad_in_i,
  output logic [NPIN-1:0]   native_in_o,
  output logic [NPIN-1:0]   pad_oe_o
);
  localparam logic [NPIN-1:0] STRAP_BIT = NPIN'(1) << STRAP_PIN;

  logic [NPIN-1:0] use_q, io_q, use_eff;
  logic [NPIN-1:0] we_use, we_io;
  logic            sel_use, sel_io, wr_ok;

  assign sel_use = (addr_i == MODE_OFS);
  assign sel_io  = (addr_i == DIR_OFS);
  assign wr_ok   = wr_en_i && !lock_i;
  assign use_eff = use_q & ~(strap_i ? '0 : STRAP_BIT);
  assign we_use  = {NPIN{wr_ok && sel_use}};
  assign we_io   = {NPIN{wr_ok && sel_io}} & use_eff;  // native pins ignore direction writes

  gpio_reg_bank #(
    .N(NPIN), .RST_VAL(MODE_RST), .HARD(HARD_MASK), .CORE(CORE_MASK), .KEEP(KEEP_PIN)
  ) u_mode (
    .clk_i, .rst_ni, .plt_rst_i, .sw_rst_i,
    .we_i(we_use), .d_i(wdata_i), .q_o(use_q)
  );

  gpio_reg_bank #(
    .N(NPIN), .RST_VAL(DIR_RST), .HARD('0), .CORE(CORE_MASK), .KEEP(KEEP_PIN)
  ) u_dir (
    .clk_i, .rst_ni, .plt_rst_i, .sw_rst_i,
    .we_i(we_io), .d_i(wdata_i), .q_o(io_q)
  );

  gpio_pin_mux #(.N(NPIN), .INACTIVE(INACTIVE_LVL)) u_mux (
    .gpio_mode_i(use_eff), .dir_in_i(io_q), .pad_in_i,
    .native_in_o, .pad_oe_o
  );

  always_comb begin
    if (sel_use)     rdata_o = use_eff;
    else if (sel_io) rdata_o = io_q & use_eff;
    else             rdata_o = '0;
  end
endmodule

// File: rtl/gpio_mux_ctrl_chk.sv
module gpio_mux_ctrl_chk
  import gpio_mux_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              plt_rst_i,
  input logic              sw_rst_i,
  input logic              lock_i,
  input logic              strap_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPIN-1:0]   rdata_o,
  input logic [NPIN-1:0]   pad_oe_o,
  input logic [NPIN-1:0]   use_eff,
  input logic [NPIN-1:0]   use_q,
  input logic [NPIN-1:0]   io_q
);
  localparam logic [NPIN-1:0] KEEP_BIT = NPIN'(1) << KEEP_PIN;

  assert_hard_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == MODE_OFS) |-> ((rdata_o & HARD_MASK) == HARD_MASK));

  assert_strap_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strap_i && addr_i == MODE_OFS) |-> !rdata_o[STRAP_PIN]);

  assert_native_dir_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == DIR_OFS) |-> ((rdata_o & ~use_eff) == '0));

  assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && wr_en_i && !plt_rst_i && !sw_rst_i) |=> ($stable(use_q) && $stable(io_q)));

  assert_plt_core_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plt_rst_i |=> ((((use_q ^ MODE_RST) | (io_q ^ DIR_RST)) & CORE_MASK) == '0));

  assert_soft_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> ((((use_q ^ MODE_RST) | (io_q ^ DIR_RST)) & ~KEEP_BIT) == '0));

  assert_oe_gpio_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~use_eff) == '0));

  assert_bad_addr_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != MODE_OFS && addr_i != DIR_OFS) |-> (rdata_o == '0));
endmodule

bind gpio_mux_ctrl gpio_mux_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .plt_rst_i(plt_rst_i), .sw_rst_i(sw_rst_i),
  .lock_i(lock_i), .strap_i(strap_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .pad_oe_o(pad_oe_o), .use_eff(use_eff),
  .use_q(use_q), .io_q(io_q)
);

// File: tb/gpio_mux_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_mux_ctrl_tb;
  logic        clk = 0, rst_n = 0, plt = 0, sw = 0, lock = 0, strap = 1, wr = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, pad_in = 0;
  logic [31:0] rdata, native_in, pad_oe;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  logic [31:0] m_use = 32'hB96B_A1FF, m_io = 32'hF6FF_6EFF;

  always #2.5 clk = ~clk;

  gpio_mux_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .plt_rst_i(plt), .sw_rst_i(sw), .lock_i(lock),
    .strap_i(strap), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .pad_in_i(pad_in), .native_in_o(native_in), .pad_oe_o(pad_oe)
  );

  function automatic logic [31:0] eff_mode(logic [31:0] u, logic s);
    logic [31:0] e = u | 32'h1900_8100;           // pins 8,15,24,27,28 wired to GPIO
    if (!s) e[29] = 1'b0;
    return e;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s t=%0t actual=%08h expected=%08h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [31:0] nu, nio, rm, e;
    if (rst_n) begin
      e = eff_mode(m_use, strap);
      nu = m_use; nio = m_io;
      if (wr && !lock && addr == 4'h0) nu = wdata;
      if (wr && !lock && addr == 4'h4) nio = (m_io & ~e) | (wdata & e);
      rm = 0;
      if (sw)  rm = rm | ~(32'h1 << 24);
      if (plt) rm = rm | 32'h00FF_00FF;
      m_use = (nu & ~rm) | (32'hB96B_A1FF & rm);
      m_io  = (nio & ~rm) | (32'hF6FF_6EFF & rm);
    end
    #1;
    if (rst_n && !done) begin
      e = eff_mode(m_use, strap);
      check({cur_req, " rdata"},
            (addr == 4'h0) ? e : (addr == 4'h4) ? (m_io & e) : 32'h0, 32'h0 ^ rdata);
      check("R9 native_in", native_in, (e & 32'h0000_FFFF) | (~e & pad_in));
      check("R10 pad_oe", pad_oe, e & ~m_io);
    end
  end

  always @(negedge rst_n) begin
    m_use = 32'hB96B_A1FF; m_io = 32'hF6FF_6EFF;
  end

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd(logic [3:0] a);
    @(negedge clk); addr = a;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R2 reset values, explicit
    cur_req = "R1"; rd(4'h0);
    check("R1 mode reset", rdata, 32'hB96B_A1FF);
    cur_req = "R2"; rd(4'h4);
    check("R2 dir reset", rdata, 32'hF6FF_6EFF & 32'hB96B_A1FF);
    // R3 wired bits
    cur_req = "R3"; wr_reg(4'h0, 32'h0); rd(4'h0);
    check("R3 wired ones", rdata, 32'h1900_8100);
    // R5 direction writes masked by mode
    cur_req = "R5"; wr_reg(4'h4, 32'h0000_0000); rd(4'h4);
    wr_reg(4'h0, 32'hFFFF_FFFF); rd(4'h4);
    check("R5 masked dir", rdata, 32'hF6FF_6EFF & ~32'h1900_8100);
    wr_reg(4'h4, 32'h1234_5678); rd(4'h4);
    check("R5 dir write", rdata, 32'h1234_5678);
    wr_reg(4'h0, 32'h0F0F_0F0F); rd(4'h4);
    // R9 R10 pad patterns
    cur_req = "R9";
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); pad_in = 32'hA5A5_5A5A ^ (32'h1111_1111 * k);
    end
    // R4 strap gating on pin 29
    cur_req = "R4"; wr_reg(4'h0, 32'h2000_0000); strap = 0; rd(4'h0);
    check("R4 strap low", rdata[29], 1'b0);
    strap = 1; rd(4'h0);
    check("R4 strap high", rdata[29], 1'b1);
    // R6 lock
    cur_req = "R6"; wr_reg(4'h0, 32'hFFFF_FFFF); wr_reg(4'h4, 32'hDEAD_BEEF);
    lock = 1; wr_reg(4'h0, 32'h0); wr_reg(4'h4, 32'h0); rd(4'h4);
    check("R6 locked dir", rdata, 32'hDEAD_BEEF);
    rd(4'h0); check("R6 locked mode", rdata, 32'hFFFF_FFFF);
    lock = 0;
    // R7 platform reset
    cur_req = "R7"; wr_reg(4'h4, 32'h0F0F_F0F0);
    @(negedge clk); plt = 1; @(negedge clk); plt = 0;
    rd(4'h0); check("R7 plt mode", rdata, (32'hFFFF_FFFF & ~32'h00FF_00FF) | (32'hB96B_A1FF & 32'h00FF_00FF));
    // R8 software reset keeps pin 24
    cur_req = "R8"; wr_reg(4'h0, 32'hFFFF_FFFF); wr_reg(4'h4, 32'h0100_0000);
    @(negedge clk); sw = 1; @(negedge clk); sw = 0;
    rd(4'h4); check("R8 dir pin24 kept", rdata, (32'hF6FF_6EFF | 32'h0100_0000) & 32'hB96B_A1FF);
    // R11 other offsets
    cur_req = "R11"; wr_reg(4'h8, 32'h0); rd(4'h8);
    check("R11 bad read", rdata, 32'h0);
    rd(4'h0); check("R11 mode untouched", rdata, 32'hB96B_A1FF);
    wr_reg(4'hC, 32'h0); rd(4'h4);
    // R12 async full reset
    cur_req = "R12"; wr_reg(4'h0, 32'h0); addr = 4'h0;
    @(posedge clk); #1.2; rst_n = 0; #0.3;
    check("R12 async reset", rdata, 32'hB96B_A1FF);
    @(negedge clk); @(negedge clk); rst_n = 1;
    rd(4'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule